// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block collects interrupt requests from sixteen configurable lines and two fixed-rank sources: a non-maskable request and a fault request. Each request pulse sets a pending bit. Every cycle the arbiter picks the best pending source. It then decides whether that source may interrupt the handler now running. When it may, the block issues a one-cycle entry strobe carrying the source number. At the same edge it clears that source's pending bit and records the source's rank on a small stack of active handlers. A return strobe from the handler removes the top entry, so handlers can nest up to the stack depth.

Each configurable line has a 4-bit priority, where a smaller value wins. A split input divides the priority into two fields. The upper bits form the group, and only the group decides whether a source can interrupt a running handler. The lower bits form the sub-order, which only ranks sources that are waiting together. A setting above 4 is treated as 4.

Source numbers are 0 for the non-maskable source, 1 for the fault source, and 2+k for line k. The execution rank on `exec_prio_o` is 0 for the non-maskable source, 1 for the fault source, and group+2 for a line. It reads all ones (31) when no handler is active.

Top module: `irq_arbiter`

## Requirements
- R1: After reset all pending bits are 0, the stack depth is 0, `exec_prio_o` is 31, `entry_o` is low, and every line priority is 0.
- R2: A numerically smaller priority ranks higher. With split 0, of two pending lines the one with the smaller value is entered first.
- R3: The non-maskable source (number 0, rank 0) ranks above the fault source (number 1, rank 1). Both rank above any line, whatever its priority.
- R4: Among pending sources whose group and sub-order are equal, the lowest source number is entered first.
- R5: A source interrupts a running handler only if its rank is strictly smaller than `exec_prio_o`. A source of equal rank is not entered and keeps its pending bit set.
- R6: With split s (0..4), the low s bits of a priority are the sub-order and the rest are the group. Only the group sets the rank, and the sub-order orders pending sources of equal group.
- R7: A split value above 4 behaves exactly like 4, so every line then has group 0.
- R8: A request pulse sets the pending bit at the next clock edge. In the following cycle the arbiter may decide to enter that source. At the edge after that decision, `entry_o` goes high for one cycle with the source number, the pending bit clears, the rank is pushed, and `exec_prio_o` shows the new rank.
- R9: A return strobe pops the stack. With the stack empty, any pending source can be entered.
- R10: No entry is issued while the stack holds 4 handlers. Requests stay pending until a return frees a slot.
- R11: A priority write takes effect for arbitration from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 16 | Request pulses of the configurable lines |
| nmi_req_i | input | 1 | Non-maskable request pulse |
| fault_req_i | input | 1 | Fault request pulse |
| prio_we_i | input | 1 | Priority write enable |
| prio_idx_i | input | 4 | Line index to write |
| prio_val_i | input | 4 | Priority value to write |
| split_i | input | 3 | Number of low sub-order bits (clamped to 4) |
| ret_i | input | 1 | Handler return strobe |
| entry_o | output | 1 | One-cycle entry strobe |
| entry_src_o | output | 5 | Source number entered |
| pending_o | output | 18 | Pending bits, indexed by source number |
| depth_o | output | 3 | Active stack depth |
| exec_prio_o | output | 5 | Rank of the running handler, 31 when idle |

## Verification
The tests drive lines with distinct priorities, so the entry order shows that the smaller value wins. They also drive equal priorities on lines with different numbers, which separates a number-based tie break from a value-based one. Fixed sources are raised together with priority-0 lines, which shows that the fixed ranks sit above every configurable value. Split settings of 2 and 7 are run against pairs that share a group but differ in sub-order, or that differ in value but share a group once clamped. These pairs separate ordering among waiting sources from preemption. A chain of four nested entries followed by a non-maskable request checks that a full stack blocks entry and that a return releases it.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned SPLIT_W     = 3;
  localparam int unsigned FIXED_SRCS  = 2;
  localparam int unsigned NMI_RANK    = 0;
  localparam int unsigned FAULT_RANK  = 1;
  localparam int unsigned LINE_OFFSET = 2;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs #(
  parameter int unsigned N_IRQ  = 16,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [PRIO_W-1:0]             val_i,
  output logic [N_IRQ-1:0][PRIO_W-1:0]  prio_o
);
  for (genvar k = 0; k < N_IRQ; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                prio_o[k] <= '0;
      else if (we_i && idx_i == IDX_W'(k))        prio_o[k] <= val_i;
    end
  end
endmodule

// File: rtl/irq_select.sv
module irq_select #(
  parameter int unsigned NSRC  = 18,
  parameter int unsigned KEY_W = 9,
  localparam int unsigned SRC_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0][KEY_W-1:0] keys_i,
  input  logic [NSRC-1:0]            valid_i,
  output logic                       win_vld_o,
  output logic [SRC_W-1:0]           win_src_o,
  output logic [KEY_W-1:0]           win_key_o
);
  // ascending scan, strict compare keeps the lowest index on ties
  always_comb begin
    win_vld_o = 1'b0;
    win_src_o = '0;
    win_key_o = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (valid_i[i] && (!win_vld_o || keys_i[i] < win_key_o)) begin
        win_vld_o = 1'b1;
        win_src_o = SRC_W'(i);
        win_key_o = keys_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_active_stack.sv
module irq_active_stack #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned EG_W  = 5,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [EG_W-1:0]  push_val_i,
  input  logic             pop_i,
  output logic             full_o,
  output logic [CNT_W-1:0] depth_o,
  output logic [EG_W-1:0]  top_o
);
  logic [DEPTH-1:0][EG_W-1:0] stk_q;
  logic [CNT_W-1:0]           cnt_q;
  logic                       do_pop;
  logic [CNT_W-1:0]           base;
  logic [CNT_W-1:0]           wr_idx;

  assign do_pop = pop_i && (cnt_q != '0);
  assign base   = do_pop ? cnt_q - CNT_W'(1) : cnt_q;
  assign wr_idx = base;
  assign full_o = (cnt_q == CNT_W'(DEPTH));
  assign depth_o = cnt_q;

  always_comb begin
    top_o = '1;
    for (int i = 0; i < DEPTH; i++)
      if (cnt_q == CNT_W'(i + 1)) top_o = stk_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (push_i && (base != CNT_W'(DEPTH))) begin
      cnt_q <= base + CNT_W'(1);
    end else begin
      cnt_q <= base;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  stk_q[i] <= '0;
      else if (push_i && wr_idx == CNT_W'(i))       stk_q[i] <= push_val_i;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_IRQ   = 16,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned STACK_D = 4,
  localparam int unsigned NSRC   = N_IRQ + FIXED_SRCS,
  localparam int unsigned SRC_W  = $clog2(NSRC),
  localparam int unsigned IDX_W  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
  localparam int unsigned EG_W   = PRIO_W + 1,
  localparam int unsigned KEY_W  = EG_W + PRIO_W,
  localparam int unsigned DEP_W  = $clog2(STACK_D + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_IRQ-1:0]   irq_req_i,
  input  logic               nmi_req_i,
  input  logic               fault_req_i,
  input  logic               prio_we_i,
  input  logic [IDX_W-1:0]   prio_idx_i,
  input  logic [PRIO_W-1:0]  prio_val_i,
  input  logic [SPLIT_W-1:0] split_i,
  input  logic               ret_i,
  output logic               entry_o,
  output logic [SRC_W-1:0]   entry_src_o,
  output logic [NSRC-1:0]    pending_o,
  output logic [DEP_W-1:0]   depth_o,
  output logic [EG_W-1:0]    exec_prio_o
);
  logic [N_IRQ-1:0][PRIO_W-1:0] prio;
  logic [NSRC-1:0][KEY_W-1:0]   keys;
  logic [NSRC-1:0]              pend_q;
  logic [NSRC-1:0]              req_vec;
  logic [NSRC-1:0]              clr_vec;
  logic [SPLIT_W-1:0]           split_eff;
  logic                         win_vld;
  logic [SRC_W-1:0]             win_src;
  logic [KEY_W-1:0]             win_key;
  logic [EG_W-1:0]              win_eg;
  logic [EG_W-1:0]              top_eg;
  logic                         stk_full;
  logic                         take;
  logic                         entry_q;
  logic [SRC_W-1:0]             src_q;

  irq_prio_regs #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (prio_we_i),
    .idx_i  (prio_idx_i),
    .val_i  (prio_val_i),
    .prio_o (prio)
  );

  assign split_eff = (int'(split_i) > int'(PRIO_W)) ? SPLIT_W'(PRIO_W) : split_i;

  assign keys[0] = {EG_W'(NMI_RANK), PRIO_W'(0)};
  assign keys[1] = {EG_W'(FAULT_RANK), PRIO_W'(0)};

  for (genvar k = 0; k < N_IRQ; k++) begin : g_key
    logic [PRIO_W-1:0] grp;
    logic [PRIO_W-1:0] sub_mask;
    assign grp      = prio[k] >> split_eff;
    assign sub_mask = ~({PRIO_W{1'b1}} << split_eff);
    assign keys[k + LINE_OFFSET] = {EG_W'(grp) + EG_W'(LINE_OFFSET), prio[k] & sub_mask};
  end

  irq_select #(.NSRC(NSRC), .KEY_W(KEY_W)) u_sel (
    .keys_i    (keys),
    .valid_i   (pend_q),
    .win_vld_o (win_vld),
    .win_src_o (win_src),
    .win_key_o (win_key)
  );

  assign win_eg = win_key[KEY_W-1 -: EG_W];
  assign take   = win_vld && (win_eg < top_eg) && !stk_full;

  irq_active_stack #(.DEPTH(STACK_D), .EG_W(EG_W)) u_stk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (take),
    .push_val_i (win_eg),
    .pop_i      (ret_i),
    .full_o     (stk_full),
    .depth_o    (depth_o),
    .top_o      (top_eg)
  );

  assign req_vec = {irq_req_i, fault_req_i, nmi_req_i};

  always_comb begin
    clr_vec = '0;
    if (take) clr_vec[win_src] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      entry_q <= 1'b0;
      src_q   <= '0;
    end else begin
      pend_q  <= (pend_q & ~clr_vec) | req_vec;
      entry_q <= take;
      if (take) src_q <= win_src;
    end
  end

  assign entry_o     = entry_q;
  assign entry_src_o = src_q;
  assign pending_o   = pend_q;
  assign exec_prio_o = top_eg;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int unsigned N_IRQ   = 16,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned STACK_D = 4,
  localparam int unsigned NSRC   = N_IRQ + 2,
  localparam int unsigned SRC_W  = $clog2(NSRC),
  localparam int unsigned EG_W   = PRIO_W + 1,
  localparam int unsigned DEP_W  = $clog2(STACK_D + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ret_i,
  input logic             entry_o,
  input logic [SRC_W-1:0] entry_src_o,
  input logic [NSRC-1:0]  pending_o,
  input logic [DEP_W-1:0] depth_o,
  input logic [EG_W-1:0]  exec_prio_o
);
  logic [NSRC-1:0] prev_pend;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_pend <= '0;
    else         prev_pend <= pending_o;
  end

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= DEP_W'(STACK_D));

  p_full_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_o == DEP_W'(STACK_D)) |=> !entry_o);

  p_strict_preempt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> (exec_prio_o < $past(exec_prio_o)));

  p_push_on_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_o && !$past(ret_i)) |-> (depth_o == $past(depth_o) + DEP_W'(1)));

  p_was_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> prev_pend[entry_src_o]);

  p_empty_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_o == '0) |-> (exec_prio_o == '1));
endmodule

bind irq_arbiter irq_arbiter_chk #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .STACK_D(STACK_D)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ret_i       (ret_i),
  .entry_o     (entry_o),
  .entry_src_o (entry_src_o),
  .pending_o   (pending_o),
  .depth_o     (depth_o),
  .exec_prio_o (exec_prio_o)
);

// File: tb/irq_arbiter_test.sv
`timescale 1ns/1ps
module irq_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_req = '0;
  logic        nmi_req = 1'b0, fault_req = 1'b0;
  logic        prio_we = 1'b0;
  logic [3:0]  prio_idx = '0, prio_val = '0;
  logic [2:0]  split = '0;
  logic        ret = 1'b0;
  logic        entry_o;
  logic [4:0]  entry_src_o;
  logic [17:0] pending_o;
  logic [2:0]  depth_o;
  logic [4:0]  exec_prio_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_arbiter uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq_req), .nmi_req_i(nmi_req),
    .fault_req_i(fault_req), .prio_we_i(prio_we), .prio_idx_i(prio_idx),
    .prio_val_i(prio_val), .split_i(split), .ret_i(ret), .entry_o(entry_o),
    .entry_src_o(entry_src_o), .pending_o(pending_o), .depth_o(depth_o),
    .exec_prio_o(exec_prio_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_prio(input int idx, input int val);
    @(negedge clk); prio_we = 1'b1; prio_idx = 4'(idx); prio_val = 4'(val);
    @(negedge clk); prio_we = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] lines, input bit nmi, input bit flt);
    @(negedge clk); irq_req = lines; nmi_req = nmi; fault_req = flt;
    @(negedge clk); irq_req = '0; nmi_req = 1'b0; fault_req = 1'b0;
  endtask

  task automatic ret_pulse();
    @(negedge clk); ret = 1'b1;
    @(negedge clk); ret = 1'b0;
  endtask

  task automatic expect_entry(input string tag, input int src, input int ex, input int dep);
    bit got = 1'b0;
    int s = -1;
    repeat (10) begin
      @(negedge clk);
      if (entry_o) begin got = 1'b1; s = int'(entry_src_o); break; end
    end
    chk({tag, " entry seen"}, int'(got), 1);
    chk({tag, " source"}, s, src);
    chk({tag, " exec rank"}, int'(exec_prio_o), ex);
    chk({tag, " depth"}, int'(depth_o), dep);
  endtask

  task automatic expect_none(input string tag, input int cycles);
    bit seen = 1'b0;
    repeat (cycles) begin
      @(negedge clk);
      if (entry_o) seen = 1'b1;
    end
    chk({tag, " no entry"}, int'(seen), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 pending", int'(pending_o), 0);
    chk("R1 depth", int'(depth_o), 0);
    chk("R1 exec idle", int'(exec_prio_o), 31);
    chk("R1 entry low", int'(entry_o), 0);
  endtask

  task automatic t_timing();
    @(negedge clk); irq_req = 16'h0008;
    @(negedge clk); irq_req = '0;
    chk("R8 pending set", int'(pending_o[5]), 1);
    chk("R8 entry not yet", int'(entry_o), 0);
    @(negedge clk);
    chk("R8 entry high", int'(entry_o), 1);
    chk("R8 source (R1 prio 0)", int'(entry_src_o), 5);
    chk("R8 pending cleared", int'(pending_o[5]), 0);
    chk("R8 rank pushed", int'(exec_prio_o), 2);
    @(negedge clk);
    chk("R8 one cycle", int'(entry_o), 0);
    ret_pulse();
    chk("R9 pop depth", int'(depth_o), 0);
    chk("R9 pop idle", int'(exec_prio_o), 31);
  endtask

  task automatic t_order();
    set_prio(0, 5);
    set_prio(1, 3);
    pulse(16'h0003, 1'b0, 1'b0);
    expect_entry("R2 R11 smaller value", 3, 5, 1);
    expect_none("R5 lower rank", 5);
    chk("R5 kept pending", int'(pending_o[2]), 1);
    set_prio(2, 3);
    pulse(16'h0004, 1'b0, 1'b0);
    expect_none("R5 equal rank", 5);
    chk("R5 equal kept pending", int'(pending_o[4]), 1);
    ret_pulse();
    expect_entry("R9 after return", 4, 5, 1);
    ret_pulse();
    expect_entry("R2 next", 2, 7, 1);
    ret_pulse();
    chk("R9 drained", int'(depth_o), 0);
  endtask

  task automatic t_tie();
    set_prio(2, 9);
    set_prio(7, 9);
    pulse(16'h0084, 1'b0, 1'b0);
    expect_entry("R4 lowest number", 4, 11, 1);
    ret_pulse();
    expect_entry("R4 second", 9, 11, 1);
    ret_pulse();
  endtask

  task automatic t_fixed();
    set_prio(0, 0);
    pulse(16'h0001, 1'b1, 1'b1);
    expect_entry("R3 nmi first", 0, 0, 1);
    expect_none("R3 fault waits", 4);
    ret_pulse();
    expect_entry("R3 fault before line", 1, 1, 1);
    ret_pulse();
    expect_entry("R3 line last", 2, 2, 1);
    ret_pulse();
    chk("R3 drained", int'(pending_o), 0);
  endtask

  task automatic t_split();
    @(negedge clk); split = 3'd2;
    set_prio(4, 6);
    set_prio(5, 5);
    set_prio(6, 3);
    pulse(16'h0030, 1'b0, 1'b0);
    expect_entry("R6 sub-order", 7, 3, 1);
    expect_none("R6 same group", 5);
    chk("R6 kept pending", int'(pending_o[6]), 1);
    pulse(16'h0040, 1'b0, 1'b0);
    expect_entry("R6 higher group preempts", 8, 2, 2);
    ret_pulse();
    expect_none("R6 back in group 1", 4);
    chk("R6 depth after pop", int'(depth_o), 1);
    ret_pulse();
    expect_entry("R6 waiting served", 6, 3, 1);
    ret_pulse();
    @(negedge clk); split = 3'd0;
  endtask

  task automatic t_clamp();
    @(negedge clk); split = 3'd7;
    set_prio(8, 15);
    set_prio(9, 0);
    pulse(16'h0100, 1'b0, 1'b0);
    expect_entry("R7 all group 0", 10, 2, 1);
    pulse(16'h0200, 1'b0, 1'b0);
    expect_none("R7 no preempt", 5);
    chk("R7 kept pending", int'(pending_o[11]), 1);
    ret_pulse();
    expect_entry("R7 after return", 11, 2, 1);
    ret_pulse();
    @(negedge clk); split = 3'd0;
  endtask

  task automatic t_full();
    set_prio(10, 12);
    set_prio(11, 8);
    set_prio(12, 4);
    set_prio(13, 0);
    pulse(16'h0400, 1'b0, 1'b0);
    expect_entry("R10 nest 1", 12, 14, 1);
    pulse(16'h0800, 1'b0, 1'b0);
    expect_entry("R10 nest 2", 13, 10, 2);
    pulse(16'h1000, 1'b0, 1'b0);
    expect_entry("R10 nest 3", 14, 6, 3);
    pulse(16'h2000, 1'b0, 1'b0);
    expect_entry("R10 nest 4", 15, 2, 4);
    pulse(16'h0000, 1'b1, 1'b0);
    expect_none("R10 full stack", 6);
    chk("R10 nmi pending", int'(pending_o[0]), 1);
    ret_pulse();
    expect_entry("R10 slot freed", 0, 0, 4);
    repeat (4) ret_pulse();
    chk("R10 drained depth", int'(depth_o), 0);
    chk("R10 drained pending", int'(pending_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_timing();
    t_order();
    t_tie();
    t_fixed();
    t_split();
    t_clamp();
    t_full();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule